// File: doc/BRIEF.md
# Virtual Pipeline Stage Scheduler

This block time-shares a small set of identical physical pipeline stages among a longer list of virtual stages. After a start pulse it takes configuration words from a valid/ready stream. It loads one word per accepted transfer, so at most one physical stage is written in any cycle, and the other stages keep executing. Virtual stages are issued in cyclic order 0, 1, …, N-1, 0, … and each one is placed on physical stage (v mod P).

When the target physical stage already holds a virtual stage, the scheduler raises a save strobe that names the outgoing stage, so that its state can be copied out of the fabric. When the incoming virtual stage was saved earlier, it raises a restore strobe in the same cycle. A per-stage residency map and an execute mask show which virtual stage each physical stage holds and which stages run in the current cycle. When there are no more virtual stages than physical stages, every configuration stays resident after one pass, and the configuration stream is closed.

Back-pressure: `cfg_ready` is high only while the schedule needs more loads and no start pulse is present. A word is consumed only in a cycle where both `cfg_valid` and `cfg_ready` are high. A cycle without `cfg_valid` is a bubble: nothing is loaded and the schedule position is held. The source must keep a word stable until it is accepted.

Top module: `vstage_sched`

## Requirements
- R1: While reset is asserted and after its release, `cfg_ready`, `load_en`, `save_en`, `restore_en`, `stage_valid` and `exec_mask` are all zero.
- R2: A start pulse latches the counts and clears the residency map and all saved-state marks. A physical count of 0 is treated as 1, and one above P_MAX is treated as P_MAX. A virtual count above V_MAX is treated as V_MAX. A virtual count of 0 loads nothing.
- R3: A configuration word is accepted only when `cfg_valid` and `cfg_ready` are both high. In the next cycle `load_en` is high for exactly that cycle and `load_cfg` carries the accepted word. A cycle without `cfg_valid` produces no load and does not advance the schedule.
- R4: Successive loads carry virtual indices 0, 1, …, N-1 and then wrap to 0. N is the latched virtual count.
- R5: Each load targets physical stage `load_phys` = `load_virt` mod P. P is the latched physical count.
- R6: In the cycle `load_en` is high, the slice `stage_virt[load_phys*VW +: VW]` already shows the new virtual index and `stage_valid[load_phys]` is 1. `exec_mask` equals `stage_valid` with the bit of the stage being loaded cleared, so a stage executes from the cycle after its load.
- R7: When a load targets a physical stage that already holds a stage, `save_en` is high in the same cycle as `load_en`, and `save_virt` is the index of the outgoing stage. A load into an empty stage gives no save.
- R8: `restore_en` is high together with `load_en` exactly when the incoming virtual stage was saved before since the last start. This includes the case where a stage is reloaded over itself, which saves and restores the same index. `restore_virt` equals `load_virt`.
- R9: When N ≤ P, after N loads `cfg_ready` stays low and no further loads, saves or restores occur until the next start. When N > P, the rotation continues as long as words arrive.
- R10: A start pulse during a run abandons the current schedule, and the next load is virtual stage 0 on physical stage 0 into an empty map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: latch counts and begin a new schedule |
| num_virt | input | VCW | Requested number of virtual stages |
| num_phys | input | PCW | Requested number of physical stages |
| cfg_valid | input | 1 | Configuration word present |
| cfg_ready | output | 1 | Scheduler accepts a word this cycle |
| cfg_data | input | CFG_W | Configuration word for the next virtual stage |
| load_en | output | 1 | A physical stage is being configured this cycle |
| load_phys | output | PW | Physical stage being configured |
| load_virt | output | VW | Virtual stage being placed |
| load_cfg | output | CFG_W | Configuration word being written |
| save_en | output | 1 | Strobe: copy out the state of the evicted stage |
| save_virt | output | VW | Virtual index of the evicted stage |
| restore_en | output | 1 | Strobe: bring back saved state for the incoming stage |
| restore_virt | output | VW | Virtual index to restore |
| stage_valid | output | P_MAX | Physical stage holds a virtual stage |
| stage_virt | output | P_MAX*VW | Resident virtual index per physical stage |
| exec_mask | output | P_MAX | Physical stages executing this cycle |

## Verification
With five virtual stages on three physical stages and a continuous stream, the test separates plain eviction from eviction plus restore. It also shows the uneven case where one physical stage keeps receiving the same virtual stage. A stream with periodic bubbles shows whether the schedule position holds when no word arrives. Four virtual stages on three physical stages force a self-reload, which separates a correct save-then-restore of one index from a missing restore. Fewer virtual than physical stages, zero and oversized counts, and a restart in the middle of a run cover the resident, clamping and reset-of-schedule paths.

// File: rtl/vstage_pkg.sv
package vstage_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HELD = 2'd2
  } seq_state_e;

  // Clamp a requested count into [lo, hi].
  function automatic int unsigned clamp_count(int unsigned req, int unsigned lo, int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/vstage_seq.sv
module vstage_seq
  import vstage_pkg::*;
#(
  parameter int P_MAX = 4,
  parameter int V_MAX = 8,
  localparam int PW  = (P_MAX > 1) ? $clog2(P_MAX) : 1,
  localparam int VW  = (V_MAX > 1) ? $clog2(V_MAX) : 1,
  localparam int PCW = $clog2(P_MAX + 1),
  localparam int VCW = $clog2(V_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VCW-1:0] num_virt,
  input  logic [PCW-1:0] num_phys,
  input  logic           cfg_valid,
  output logic           cfg_ready,
  output logic           take,
  output logic [VW-1:0]  cur_virt,
  output logic [PW-1:0]  cur_phys,
  output logic [VCW-1:0] nv_q,
  output logic [PCW-1:0] np_q,
  output seq_state_e     state
);

  logic [VCW-1:0] nv_eff;
  logic [PCW-1:0] np_eff;
  logic [VW-1:0]  v_q;
  logic [PW-1:0]  p_q;
  seq_state_e     state_q;
  logic           wrap_v;
  logic           wrap_p;
  logic           all_fit;

  always_comb begin
    nv_eff = VCW'(clamp_count(32'(num_virt), 0, V_MAX));
    np_eff = PCW'(clamp_count(32'(num_phys), 1, P_MAX));
  end

  assign cfg_ready = (state_q == SQ_RUN) && !start;
  assign take      = cfg_ready && cfg_valid;
  assign wrap_v    = (VCW'(v_q) == nv_q - VCW'(1));
  assign wrap_p    = (PCW'(p_q) == np_q - PCW'(1));
  assign all_fit   = (32'(nv_q) <= 32'(np_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      v_q     <= '0;
      p_q     <= '0;
      nv_q    <= '0;
      np_q    <= PCW'(1);
    end else if (start) begin
      nv_q    <= nv_eff;
      np_q    <= np_eff;
      v_q     <= '0;
      p_q     <= '0;
      state_q <= (nv_eff == '0) ? SQ_HELD : SQ_RUN;
    end else if (take) begin
      if (wrap_v) begin
        v_q <= '0;
        p_q <= '0;
        if (all_fit) state_q <= SQ_HELD;
      end else begin
        v_q <= v_q + VW'(1);
        p_q <= wrap_p ? '0 : p_q + PW'(1);
      end
    end
  end

  assign cur_virt = v_q;
  assign cur_phys = p_q;
  assign state    = state_q;

  AST_P_BELOW_NP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN) |-> (32'(p_q) < 32'(np_q))); // R5
  AST_V_BELOW_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN) |-> (32'(v_q) < 32'(nv_q))); // R4
  AST_P_TRACKS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN) |-> (32'(p_q) == 32'(v_q) % 32'(np_q))); // R5

endmodule

// File: rtl/vstage_map.sv
module vstage_map #(
  parameter int P_MAX = 4,
  parameter int V_MAX = 8,
  localparam int PW = (P_MAX > 1) ? $clog2(P_MAX) : 1,
  localparam int VW = (V_MAX > 1) ? $clog2(V_MAX) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                wr_en,
  input  logic [PW-1:0]       wr_phys,
  input  logic [VW-1:0]       wr_virt,
  input  logic [PW-1:0]       rd_phys,
  output logic                rd_valid,
  output logic [VW-1:0]       rd_virt,
  output logic [P_MAX-1:0]    stage_valid,
  output logic [P_MAX*VW-1:0] stage_virt
);

  logic [VW-1:0] virt_q [P_MAX];
  logic [P_MAX-1:0] valid_q;

  for (genvar g = 0; g < P_MAX; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (32'(wr_phys) == g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        virt_q[g]  <= '0;
      end else if (clear) begin
        valid_q[g] <= 1'b0;
        virt_q[g]  <= '0;
      end else if (hit) begin
        valid_q[g] <= 1'b1;
        virt_q[g]  <= wr_virt;
      end
    end
    assign stage_virt[g*VW +: VW] = virt_q[g];
  end

  assign stage_valid = valid_q;
  assign rd_valid    = valid_q[rd_phys];
  assign rd_virt     = virt_q[rd_phys];

  AST_ONE_SLOT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ($countones(valid_q ^ $past(valid_q)) <= 1)); // R3

endmodule

// File: rtl/vstage_ckpt.sv
module vstage_ckpt #(
  parameter int V_MAX = 8,
  localparam int VW = (V_MAX > 1) ? $clog2(V_MAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          set_en,
  input  logic [VW-1:0] set_idx,
  input  logic [VW-1:0] q_idx,
  output logic          q_hit
);

  logic [V_MAX-1:0] saved_q;

  for (genvar g = 0; g < V_MAX; g++) begin : g_mark
    always_ff @(posedge clk) begin
      if (!rst_n)                                   saved_q[g] <= 1'b0;
      else if (clear)                               saved_q[g] <= 1'b0;
      else if (set_en && (32'(set_idx) == g))       saved_q[g] <= 1'b1;
    end
  end

  assign q_hit = saved_q[q_idx];

  AST_MARKS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (($past(saved_q) & ~saved_q) == '0)); // R8

endmodule

// File: rtl/vstage_sched.sv
module vstage_sched
  import vstage_pkg::*;
#(
  parameter int P_MAX = 4,
  parameter int V_MAX = 8,
  parameter int CFG_W = 16,
  localparam int PW  = (P_MAX > 1) ? $clog2(P_MAX) : 1,
  localparam int VW  = (V_MAX > 1) ? $clog2(V_MAX) : 1,
  localparam int PCW = $clog2(P_MAX + 1),
  localparam int VCW = $clog2(V_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [VCW-1:0]      num_virt,
  input  logic [PCW-1:0]      num_phys,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [CFG_W-1:0]    cfg_data,
  output logic                load_en,
  output logic [PW-1:0]       load_phys,
  output logic [VW-1:0]       load_virt,
  output logic [CFG_W-1:0]    load_cfg,
  output logic                save_en,
  output logic [VW-1:0]       save_virt,
  output logic                restore_en,
  output logic [VW-1:0]       restore_virt,
  output logic [P_MAX-1:0]    stage_valid,
  output logic [P_MAX*VW-1:0] stage_virt,
  output logic [P_MAX-1:0]    exec_mask
);

  logic           take;
  logic [VW-1:0]  cur_virt;
  logic [PW-1:0]  cur_phys;
  logic [VCW-1:0] nv_q;
  logic [PCW-1:0] np_q;
  seq_state_e     seq_state;
  logic           res_valid;
  logic [VW-1:0]  res_virt;
  logic           was_saved;
  logic           evict;
  logic           self_reload;
  logic [P_MAX-1:0] load_onehot;

  vstage_seq #(.P_MAX(P_MAX), .V_MAX(V_MAX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .num_virt  (num_virt),
    .num_phys  (num_phys),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .take      (take),
    .cur_virt  (cur_virt),
    .cur_phys  (cur_phys),
    .nv_q      (nv_q),
    .np_q      (np_q),
    .state     (seq_state)
  );

  vstage_map #(.P_MAX(P_MAX), .V_MAX(V_MAX)) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start),
    .wr_en       (take),
    .wr_phys     (cur_phys),
    .wr_virt     (cur_virt),
    .rd_phys     (cur_phys),
    .rd_valid    (res_valid),
    .rd_virt     (res_virt),
    .stage_valid (stage_valid),
    .stage_virt  (stage_virt)
  );

  assign evict       = take && res_valid;
  assign self_reload = res_valid && (res_virt == cur_virt);

  vstage_ckpt #(.V_MAX(V_MAX)) u_ckpt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .set_en  (evict),
    .set_idx (res_virt),
    .q_idx   (cur_virt),
    .q_hit   (was_saved)
  );

  // Event outputs: strobes live for one cycle, indices are held between loads.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_en      <= 1'b0;
      save_en      <= 1'b0;
      restore_en   <= 1'b0;
      load_phys    <= '0;
      load_virt    <= '0;
      load_cfg     <= '0;
      save_virt    <= '0;
      restore_virt <= '0;
    end else begin
      load_en    <= take;
      save_en    <= evict;
      restore_en <= take && (was_saved || self_reload);
      if (take) begin
        load_phys    <= cur_phys;
        load_virt    <= cur_virt;
        load_cfg     <= cfg_data;
        restore_virt <= cur_virt;
      end
      if (evict) save_virt <= res_virt;
    end
  end

  always_comb begin
    load_onehot = '0;
    if (load_en) load_onehot[load_phys] = 1'b1;
  end

  assign exec_mask = stage_valid & ~load_onehot;

  AST_SAVE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |-> load_en); // R7
  AST_RESTORE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> load_en); // R8
  AST_VIRT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (32'(load_virt) < 32'(nv_q))); // R4
  AST_PHYS_IS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (32'(load_phys) == 32'(load_virt) % 32'(np_q))); // R5
  AST_MAP_SHOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (stage_valid[load_phys] && (stage_virt[load_phys*VW +: VW] == load_virt))); // R6
  AST_HELD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == SQ_HELD) && !start) |=> !load_en); // R9
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (!load_en && !save_en && !restore_en && (stage_valid == '0))); // R1

endmodule

// File: tb/vstage_sched_test.sv
`timescale 1ns/100ps
module vstage_sched_test;

  localparam int P_MAX = 4;
  localparam int V_MAX = 8;
  localparam int CFG_W = 16;
  localparam int PW  = 2;
  localparam int VW  = 3;
  localparam int PCW = 3;
  localparam int VCW = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [VCW-1:0]      num_virt = '0;
  logic [PCW-1:0]      num_phys = '0;
  logic                cfg_valid = 1'b0;
  logic                cfg_ready;
  logic [CFG_W-1:0]    cfg_data = '0;
  logic                load_en;
  logic [PW-1:0]       load_phys;
  logic [VW-1:0]       load_virt;
  logic [CFG_W-1:0]    load_cfg;
  logic                save_en;
  logic [VW-1:0]       save_virt;
  logic                restore_en;
  logic [VW-1:0]       restore_virt;
  logic [P_MAX-1:0]    stage_valid;
  logic [P_MAX*VW-1:0] stage_virt;
  logic [P_MAX-1:0]    exec_mask;

  always #2.5 clk = ~clk;

  vstage_sched #(.P_MAX(P_MAX), .V_MAX(V_MAX), .CFG_W(CFG_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_virt(num_virt), .num_phys(num_phys),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .load_en(load_en), .load_phys(load_phys), .load_virt(load_virt), .load_cfg(load_cfg),
    .save_en(save_en), .save_virt(save_virt), .restore_en(restore_en),
    .restore_virt(restore_virt), .stage_valid(stage_valid), .stage_virt(stage_virt),
    .exec_mask(exec_mask)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  bit comparing = 0;
  string tag_phys = "R5";
  string tag_virt = "R4";

  // Behavioural reference state
  bit m_run = 0;
  int m_nv = 0, m_np = 1, m_v = 0, m_p = 0;
  bit m_res_val [P_MAX];
  int m_res_virt [P_MAX];
  bit m_saved [V_MAX];
  bit e_load = 0, e_save = 0, e_rest = 0;
  int e_phys = 0, e_virt = 0, e_cfg = 0, e_save_virt = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_nv = 0; m_np = 1; m_v = 0; m_p = 0;
      e_load = 0; e_save = 0; e_rest = 0;
      foreach (m_res_val[i]) begin m_res_val[i] = 0; m_res_virt[i] = 0; end
      foreach (m_saved[i]) m_saved[i] = 0;
    end else begin
      e_load = 0; e_save = 0; e_rest = 0;
      if (start) begin
        m_nv = (num_virt > V_MAX) ? V_MAX : int'(num_virt);
        m_np = (num_phys == 0) ? 1 : ((num_phys > P_MAX) ? P_MAX : int'(num_phys));
        m_v = 0; m_p = 0;
        m_run = (m_nv != 0);
        foreach (m_res_val[i]) begin m_res_val[i] = 0; m_res_virt[i] = 0; end
        foreach (m_saved[i]) m_saved[i] = 0;
      end else if (m_run && cfg_valid) begin
        e_load = 1; e_phys = m_p; e_virt = m_v; e_cfg = int'(cfg_data);
        e_rest = m_saved[m_v] || (m_res_val[m_p] && m_res_virt[m_p] == m_v);
        if (m_res_val[m_p]) begin
          e_save = 1; e_save_virt = m_res_virt[m_p];
          m_saved[m_res_virt[m_p]] = 1;
        end
        m_res_val[m_p] = 1; m_res_virt[m_p] = m_v;
        if (m_v == m_nv - 1) begin
          m_v = 0; m_p = 0;
          if (m_nv <= m_np) m_run = 0;
        end else begin
          m_v++;
          m_p = (m_p == m_np - 1) ? 0 : m_p + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && comparing) begin
      logic [P_MAX-1:0] vmask, xmask;
      vmask = '0;
      foreach (m_res_val[i]) vmask[i] = m_res_val[i];
      xmask = vmask;
      if (e_load) xmask[e_phys] = 1'b0;
      chk("R9", "cfg_ready", 32'(cfg_ready), 32'(m_run && !start));
      chk("R3", "load_en", 32'(load_en), 32'(e_load));
      if (e_load && load_en) begin
        chk("R3", "load_cfg", 32'(load_cfg), 32'(e_cfg));
        chk(tag_virt, "load_virt", 32'(load_virt), 32'(e_virt));
        chk(tag_phys, "load_phys", 32'(load_phys), 32'(e_phys));
      end
      chk("R7", "save_en", 32'(save_en), 32'(e_save));
      if (e_save && save_en) chk("R7", "save_virt", 32'(save_virt), 32'(e_save_virt));
      chk("R8", "restore_en", 32'(restore_en), 32'(e_rest));
      if (e_rest && restore_en) chk("R8", "restore_virt", 32'(restore_virt), 32'(e_virt));
      chk("R6", "stage_valid", 32'(stage_valid), 32'(vmask));
      chk("R6", "exec_mask", 32'(exec_mask), 32'(xmask));
      for (int i = 0; i < P_MAX; i++)
        if (m_res_val[i]) chk("R6", "stage_virt", 32'(stage_virt[i*VW +: VW]), 32'(m_res_virt[i]));
    end
  end

  int word_ctr = 0;

  task automatic do_start(int nv, int np);
    @(negedge clk); #1;
    start = 1; num_virt = VCW'(nv); num_phys = PCW'(np); cfg_valid = 1'b0;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic feed(int n, bit bubbles);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cfg_valid = bubbles ? (i % 3 != 1) : 1'b1;
      cfg_data = CFG_W'(16'hC000 + word_ctr);
      word_ctr++;
    end
    @(negedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 20000);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk("R1", "cfg_ready in reset", 32'(cfg_ready), 0);
    chk("R1", "load_en in reset", 32'(load_en), 0);
    chk("R1", "stage_valid in reset", 32'(stage_valid), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "save/restore after reset", 32'({save_en, restore_en}), 0);
    chk("R1", "exec_mask after reset", 32'(exec_mask), 0);
    comparing = 1;

    // Five virtual on three physical, continuous stream
    do_start(5, 3);
    feed(16, 1'b0);
    // Same shape with bubbles
    do_start(5, 3);
    feed(18, 1'b1);
    // Self-reload case: four on three
    do_start(4, 3);
    feed(12, 1'b0);
    // Resident case: two on four, stream stays open
    do_start(2, 4);
    feed(8, 1'b0);
    chk("R9", "no load once resident", 32'(load_en), 0);
    // Clamping
    tag_phys = "R2";
    do_start(3, 0);
    feed(7, 1'b0);
    do_start(15, 7);
    feed(20, 1'b0);
    do_start(0, 2);
    feed(4, 1'b0);
    chk("R2", "zero virtual count loads nothing", 32'(stage_valid), 0);
    tag_phys = "R5";
    // Restart in the middle of a run
    do_start(6, 4);
    feed(5, 1'b0);
    tag_virt = "R10";
    do_start(6, 4);
    chk("R10", "map empty after restart", 32'(stage_valid), 0);
    feed(3, 1'b0);
    tag_virt = "R4";
    feed(10, 1'b1);
    repeat (3) @(negedge clk);
    finished = 1;
    report();
  end

endmodule